// File: doc/BRIEF.md
# Shared Interrupt Router and Priority Arbiter

This block holds the routing and arbitration state for the shared interrupts of a multi-processor system. Interrupt numbers 0 to 31 belong to per-processor private sources. The numbers from 32 up to `NUM_IRQ-1` are shared, and each shared interrupt has this state:

- a pending latch
- an enable bit
- a group bit and a group modifier bit
- an edge/level type bit
- a sampled input level
- an 8-bit priority
- a target processor index with a separate "target implemented" bit

A single pulse on `scan_req_i` starts a full rescan. The scan walks the shared interrupts one 32-interrupt word per clock. For each word it forms an eligibility mask, and for every processor it keeps the best candidate seen so far.

When the last word has been processed, each processor's record is merged with the winner that processor's private resolver presents on the `loc_*` inputs. The merged results are published on the `best_*` outputs together with a one-cycle `done_o` pulse.

A flat input-line port carries level changes from the interrupt wires. A line index below `NUM_IRQ-32` feeds a shared interrupt. Each following block of 32 indices is decoded and forwarded, one cycle later, to the private-interrupt logic of processor 0, then processor 1, and so on. A small configuration write port updates one shared interrupt's attributes, security bits or pending latch.

`NUM_IRQ` must be a multiple of 32, at least 64 and no larger than `MAX_IRQ`.

Top module: `spi_router`

## Requirements
- R1: While `rst` is high all pending, level, enable, modifier, type, priority, target and target-valid state clears to 0, `busy_o`, `done_o`, `ppi_vld_o` and every `best_vld_o` bit are 0, and every shared group bit is loaded with the value of `rst_nonsec_i`.
- R2: A shared interrupt is eligible when all of these hold:
  - it is active, meaning its pending latch is 1, or its type bit is 0 (level) and its sampled level is 1;
  - its enable bit is 1;
  - its group admits it. Group bit 1 needs `en_grp1ns_i`. Group bit 0 with modifier 1 needs `en_grp1s_i`. Group bit 0 with modifier 0 needs `en_grp0_i`.
- R3: For each processor, the winner among eligible shared interrupts routed to it is the one with the lowest priority value. Among equal priorities the lowest interrupt number wins, and priority 0xFF can still win.
- R4: An interrupt is offered to no processor when its target-valid bit is 0 or its target index is not below `NUM_CPU`. Its pending latch is kept, so it is offered once it is retargeted and a new scan runs.
- R5: A `scan_req_i` pulse seen while idle raises `busy_o` on the next cycle for `NUM_IRQ/32-1` cycles. `done_o` pulses for one cycle as `busy_o` falls. The `best_*` outputs change only in that `done_o` cycle. A request while busy is ignored.
- R6: At the end of a scan, processor c's private candidate (`loc_vld_i[c]`) replaces the shared winner when there is no shared winner or when its priority is less than or equal to the shared winner's priority. The private number is reported zero-extended.
- R7: On a line event with index k below `NUM_IRQ-32`, interrupt k+32 takes the line level. If that interrupt is edge-type (type bit 1) and the level rises from 0 to 1, its pending latch is set.
- R8: A line event with index k in the range `NUM_IRQ-32` to `NUM_IRQ-33+32*NUM_CPU` produces `ppi_vld_o` one cycle later. The processor is `(k-(NUM_IRQ-32))/32`, the private number is `(k-(NUM_IRQ-32))%32`, and the line level is passed through.
- R9: A configuration write to number n with 32 <= n < `NUM_IRQ` acts according to `cfg_sel_i`:
  - 0 loads enable, type, priority, target and target-valid;
  - 1 loads group and modifier;
  - 2 loads the pending latch;
  - 3, or any number outside that range, changes nothing.
- R10: While `single_sec_i` is 1, every modifier bit is treated as 0 for eligibility.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_nonsec_i | input | 1 | Value loaded into all shared group bits at reset |
| en_grp0_i | input | 1 | Admit group-0 interrupts |
| en_grp1ns_i | input | 1 | Admit group-1 non-secure interrupts |
| en_grp1s_i | input | 1 | Admit group-1 secure interrupts |
| single_sec_i | input | 1 | Single security state: modifier bits ignored |
| line_vld_i | input | 1 | Line event strobe |
| line_idx_i | input | LIW | Flat line index |
| line_lvl_i | input | 1 | New line level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Field select (0 attributes, 1 security, 2 pending) |
| cfg_num_i | input | IW | Interrupt number to write |
| cfg_en_i | input | 1 | Enable value |
| cfg_edge_i | input | 1 | Type value (1 edge, 0 level) |
| cfg_prio_i | input | 8 | Priority value |
| cfg_tgt_i | input | CW | Target processor index |
| cfg_tgt_vld_i | input | 1 | Target implemented |
| cfg_grp_i | input | 1 | Group value |
| cfg_mod_i | input | 1 | Modifier value |
| cfg_pend_i | input | 1 | Pending value |
| loc_vld_i | input | NUM_CPU | Private winner present, per processor |
| loc_num_i | input | 5*NUM_CPU | Private winner number, per processor |
| loc_prio_i | input | 8*NUM_CPU | Private winner priority, per processor |
| scan_req_i | input | 1 | Start a full rescan |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle scan completion pulse |
| best_vld_o | output | NUM_CPU | A winner exists, per processor |
| best_num_o | output | IW*NUM_CPU | Winning interrupt number, per processor |
| best_prio_o | output | 8*NUM_CPU | Winning priority, per processor |
| ppi_vld_o | output | 1 | Decoded private line event |
| ppi_cpu_o | output | CW | Processor of the private event |
| ppi_num_o | output | 5 | Private interrupt number |
| ppi_lvl_o | output | 1 | Private event level |

## Verification
A wrong per-processor record shows at the ports only at the next `done_o` pulse, `NUM_IRQ/32-1` cycles after the request: it appears as a wrong winner number or priority. A stuck or miscounted word counter shows sooner, as a wrong `busy_o` length or a missing `done_o`.

Corrupted pending, level or routing state stays invisible until a scan includes the affected word. Tests therefore change state and then rescan, so that each such fault surfaces within one scan. A decode fault on the private line path appears one cycle after the line event.

// File: rtl/spi_rt_pkg.sv
package spi_rt_pkg;
  localparam int PW     = 8;
  localparam int PRIV_N = 32;

  typedef struct packed {
    logic en_g0;
    logic en_g1ns;
    logic en_g1s;
    logic single_sec;
  } grp_ctl_t;

  function automatic logic elig_f(logic pend, logic lvl, logic edg, logic en,
                                  logic grp, logic md, grp_ctl_t c);
    logic m, act, gm;
    m   = md & ~c.single_sec;
    act = pend | (~edg & lvl);
    gm  = (c.en_g1ns & grp) | (c.en_g1s & ~grp & m) | (c.en_g0 & ~grp & ~m);
    return act & en & gm;
  endfunction

  function automatic logic better_f(logic cv, logic [PW-1:0] cp,
                                    logic rv, logic [PW-1:0] rp);
    return cv && (!rv || cp < rp);
  endfunction
endpackage

// File: rtl/line_decode.sv
module line_decode #(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  parameter int LIW     = 7,
  parameter int IW      = 7,
  parameter int CW      = 2
) (
  input  logic           vld_i,
  input  logic [LIW-1:0] idx_i,
  output logic           shr_o,
  output logic [IW-1:0]  shr_num_o,
  output logic           prv_o,
  output logic [CW-1:0]  prv_cpu_o,
  output logic [4:0]     prv_num_o
);
  localparam int NS = NUM_IRQ - 32;

  always_comb begin : dec
    int off;
    off       = int'(idx_i) - NS;
    shr_o     = 1'b0;
    prv_o     = 1'b0;
    shr_num_o = '0;
    prv_cpu_o = '0;
    prv_num_o = '0;
    if (vld_i) begin
      if (int'(idx_i) < NS) begin
        shr_o     = 1'b1;
        shr_num_o = IW'(int'(idx_i) + 32);
      end else if (off < 32 * NUM_CPU) begin
        prv_o     = 1'b1;
        prv_cpu_o = CW'(off / 32);
        prv_num_o = 5'(off % 32);
      end
    end
  end
endmodule

// File: rtl/word_pick.sv
module word_pick
  import spi_rt_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int CW      = 2,
  parameter int IW      = 7
) (
  input  logic [31:0]           elig_i,
  input  logic [32*PW-1:0]      prio_i,
  input  logic [32*CW-1:0]      tgt_i,
  input  logic [31:0]           tv_i,
  input  logic [IW-1:0]         base_i,
  output logic [NUM_CPU-1:0]    pick_vld_o,
  output logic [NUM_CPU*IW-1:0] pick_num_o,
  output logic [NUM_CPU*PW-1:0] pick_prio_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic          v;
    logic [4:0]    n;
    logic [PW-1:0] p;
    always_comb begin
      v = 1'b0;
      n = '0;
      p = '1;
      for (int i = 0; i < 32; i++) begin
        if (elig_i[i] && tv_i[i] && tgt_i[i*CW +: CW] == CW'(c) &&
            (!v || prio_i[i*PW +: PW] < p)) begin
          v = 1'b1;
          p = prio_i[i*PW +: PW];
          n = 5'(i);
        end
      end
    end
    assign pick_vld_o[c]            = v;
    assign pick_num_o[c*IW +: IW]   = base_i + IW'(n);
    assign pick_prio_o[c*PW +: PW]  = p;
  end
endmodule

// File: rtl/spi_router.sv
module spi_router
  import spi_rt_pkg::*;
#(
  parameter int  NUM_IRQ = 96,
  parameter int  NUM_CPU = 2,
  parameter int  MAX_IRQ = 1024,
  localparam int NS  = NUM_IRQ - 32,
  localparam int NW  = NS / 32,
  localparam int WW  = (NW > 1) ? $clog2(NW) : 1,
  localparam int SW  = $clog2(NS),
  localparam int IW  = $clog2(NUM_IRQ),
  localparam int CW  = $clog2(NUM_CPU) + 1,
  localparam int LIW = $clog2(NS + 32 * NUM_CPU)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rst_nonsec_i,
  input  logic                  en_grp0_i,
  input  logic                  en_grp1ns_i,
  input  logic                  en_grp1s_i,
  input  logic                  single_sec_i,
  input  logic                  line_vld_i,
  input  logic [LIW-1:0]        line_idx_i,
  input  logic                  line_lvl_i,
  input  logic                  cfg_we_i,
  input  logic [1:0]            cfg_sel_i,
  input  logic [IW-1:0]         cfg_num_i,
  input  logic                  cfg_en_i,
  input  logic                  cfg_edge_i,
  input  logic [7:0]            cfg_prio_i,
  input  logic [CW-1:0]         cfg_tgt_i,
  input  logic                  cfg_tgt_vld_i,
  input  logic                  cfg_grp_i,
  input  logic                  cfg_mod_i,
  input  logic                  cfg_pend_i,
  input  logic [NUM_CPU-1:0]    loc_vld_i,
  input  logic [5*NUM_CPU-1:0]  loc_num_i,
  input  logic [8*NUM_CPU-1:0]  loc_prio_i,
  input  logic                  scan_req_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [NUM_CPU-1:0]    best_vld_o,
  output logic [IW*NUM_CPU-1:0] best_num_o,
  output logic [8*NUM_CPU-1:0]  best_prio_o,
  output logic                  ppi_vld_o,
  output logic [CW-1:0]         ppi_cpu_o,
  output logic [4:0]            ppi_num_o,
  output logic                  ppi_lvl_o
);
  // shared interrupt state, slot s holds interrupt number s+32
  logic [NS-1:0] pend_q, lvl_q, edg_q, en_q, grp_q, mod_q, tv_q;
  logic [PW-1:0] prio_q [NS];
  logic [CW-1:0] tgt_q  [NS];

  grp_ctl_t ctl;
  assign ctl = '{en_g0: en_grp0_i, en_g1ns: en_grp1ns_i,
                 en_g1s: en_grp1s_i, single_sec: single_sec_i};

  // input line decode
  logic          dec_shr, dec_prv;
  logic [IW-1:0] dec_num;
  logic [CW-1:0] dec_cpu;
  logic [4:0]    dec_pnum;

  line_decode #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .LIW(LIW), .IW(IW), .CW(CW))
    u_dec (.vld_i(line_vld_i), .idx_i(line_idx_i), .shr_o(dec_shr), .shr_num_o(dec_num),
           .prv_o(dec_prv), .prv_cpu_o(dec_cpu), .prv_num_o(dec_pnum));

  logic          cfg_hit, rise;
  logic [SW-1:0] cslot, lslot;
  assign cfg_hit = cfg_we_i && (cfg_num_i >= IW'(32)) && (int'(cfg_num_i) < NUM_IRQ);
  assign cslot   = SW'(int'(cfg_num_i) - 32);
  assign lslot   = SW'(int'(dec_num) - 32);
  assign rise    = dec_shr && line_lvl_i && !lvl_q[lslot] && edg_q[lslot];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0; lvl_q <= '0; edg_q <= '0; en_q <= '0;
      mod_q  <= '0; tv_q  <= '0;
      grp_q  <= {NS{rst_nonsec_i}};
      for (int s = 0; s < NS; s++) begin
        prio_q[s] <= '0;
        tgt_q[s]  <= '0;
      end
    end else begin
      if (cfg_hit) begin
        case (cfg_sel_i)
          2'd0: begin
            en_q[cslot]   <= cfg_en_i;
            edg_q[cslot]  <= cfg_edge_i;
            prio_q[cslot] <= cfg_prio_i;
            tgt_q[cslot]  <= cfg_tgt_i;
            tv_q[cslot]   <= cfg_tgt_vld_i;
          end
          2'd1: begin
            grp_q[cslot] <= cfg_grp_i;
            mod_q[cslot] <= cfg_mod_i;
          end
          2'd2: pend_q[cslot] <= cfg_pend_i;
          default: ;
        endcase
      end
      if (dec_shr) lvl_q[lslot] <= line_lvl_i;
      if (rise)    pend_q[lslot] <= 1'b1;
    end
  end

  // private line forwarding
  always_ff @(posedge clk) begin
    if (rst) begin
      ppi_vld_o <= 1'b0; ppi_cpu_o <= '0; ppi_num_o <= '0; ppi_lvl_o <= 1'b0;
    end else begin
      ppi_vld_o <= dec_prv;
      ppi_cpu_o <= dec_cpu;
      ppi_num_o <= dec_pnum;
      ppi_lvl_o <= line_lvl_i;
    end
  end

  // word scan sequencer
  logic          busy_q, done_q, last;
  logic [WW-1:0] wq;
  assign last = busy_q && (wq == WW'(NW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; done_q <= 1'b0; wq <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          wq <= wq + 1'b1;
        end
      end else if (scan_req_i) begin
        busy_q <= 1'b1;
        wq     <= '0;
      end
    end
  end
  assign busy_o = busy_q;
  assign done_o = done_q;

  // current word slice
  logic [31:0]           w_elig, w_tv;
  logic [32*PW-1:0]      w_prio;
  logic [32*CW-1:0]      w_tgt;
  logic [IW-1:0]         w_base;
  logic [NUM_CPU-1:0]    pk_vld;
  logic [NUM_CPU*IW-1:0] pk_num;
  logic [NUM_CPU*PW-1:0] pk_prio;

  always_comb begin
    for (int i = 0; i < 32; i++) begin
      w_elig[i]             = elig_f(pend_q[int'(wq)*32+i], lvl_q[int'(wq)*32+i],
                                     edg_q[int'(wq)*32+i], en_q[int'(wq)*32+i],
                                     grp_q[int'(wq)*32+i], mod_q[int'(wq)*32+i], ctl);
      w_tv[i]               = tv_q[int'(wq)*32+i];
      w_prio[i*PW +: PW]    = prio_q[int'(wq)*32+i];
      w_tgt[i*CW +: CW]     = tgt_q[int'(wq)*32+i];
    end
  end
  assign w_base = IW'((int'(wq) + 1) * 32);

  word_pick #(.NUM_CPU(NUM_CPU), .CW(CW), .IW(IW))
    u_pick (.elig_i(w_elig), .prio_i(w_prio), .tgt_i(w_tgt), .tv_i(w_tv), .base_i(w_base),
            .pick_vld_o(pk_vld), .pick_num_o(pk_num), .pick_prio_o(pk_prio));

  // per-processor best records
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_rec
    logic          rec_vld_q, nv, lwin;
    logic [IW-1:0] rec_num_q, nn;
    logic [PW-1:0] rec_prio_q, np, lprio;
    logic          take;

    assign take  = better_f(pk_vld[c], pk_prio[c*PW +: PW], rec_vld_q, rec_prio_q);
    assign nv    = take | rec_vld_q;
    assign nn    = take ? pk_num[c*IW +: IW]  : rec_num_q;
    assign np    = take ? pk_prio[c*PW +: PW] : rec_prio_q;
    assign lprio = loc_prio_i[c*8 +: 8];
    assign lwin  = loc_vld_i[c] && (!nv || lprio <= np);

    always_ff @(posedge clk) begin
      if (rst) begin
        rec_vld_q <= 1'b0; rec_num_q <= '0; rec_prio_q <= '1;
        best_vld_o[c] <= 1'b0;
        best_num_o[c*IW +: IW] <= '0;
        best_prio_o[c*8 +: 8]  <= '0;
      end else if (!busy_q && scan_req_i) begin
        rec_vld_q  <= 1'b0;
        rec_num_q  <= '0;
        rec_prio_q <= '1;
      end else if (busy_q) begin
        rec_vld_q  <= nv;
        rec_num_q  <= nn;
        rec_prio_q <= np;
        if (last) begin
          best_vld_o[c]          <= nv | lwin;
          best_num_o[c*IW +: IW] <= lwin ? IW'(loc_num_i[c*5 +: 5]) : nn;
          best_prio_o[c*8 +: 8]  <= lwin ? lprio : np;
        end
      end
    end

    // R3: within one scan a record's priority never gets worse
    a_r3_record_monotone: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !last && rec_vld_q) |=> (rec_vld_q && rec_prio_q <= $past(rec_prio_q)));

    // R4: a picked candidate is routed to this processor and implemented
    logic [SW-1:0] pslot;
    assign pslot = SW'(int'(wq) * 32 + int'(pk_num[c*IW +: IW] - w_base));
    a_r4_pick_routed: assert property (@(posedge clk) disable iff (rst)
      pk_vld[c] |-> (tv_q[pslot] && tgt_q[pslot] == CW'(c)));
  end

  // R5: done is a single-cycle pulse at the end of busy
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(busy_q) && !busy_q));
  // R5: published results only move with done
  a_r5_results_at_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(best_prio_o) |-> done_q);
  // R8: forwarded private events name an implemented processor
  a_r8_ppi_cpu_range: assert property (@(posedge clk) disable iff (rst)
    ppi_vld_o |-> (ppi_cpu_o < CW'(NUM_CPU)));
endmodule

// File: tb/test_spi_router.sv
module test_spi_router;
  localparam int N = 96, NC = 2, IW = 7, CW = 2, LIW = 7, NSH = N - 32;

  logic clk = 0, rst = 1, rst_nonsec = 0;
  logic eg0 = 0, eg1ns = 0, eg1s = 0, ss = 0;
  logic lv = 0, ll = 0;
  logic [LIW-1:0] li = '0;
  logic cwe = 0, cen = 0, ced = 0, ctv = 0, cgr = 0, cmd = 0, cpd = 0;
  logic [1:0] csel = 0;
  logic [IW-1:0] cnum = '0;
  logic [7:0] cpr = 0;
  logic [CW-1:0] ctg = 0;
  logic [NC-1:0] locv = 0;
  logic [5*NC-1:0] locn = 0;
  logic [8*NC-1:0] locp = 0;
  logic sreq = 0;
  logic busy, done, pv, pl;
  logic [NC-1:0] bv;
  logic [IW*NC-1:0] bn;
  logic [8*NC-1:0] bp;
  logic [CW-1:0] pc;
  logic [4:0] pn;

  spi_router i_spi_router (
    .clk(clk), .rst(rst), .rst_nonsec_i(rst_nonsec), .en_grp0_i(eg0), .en_grp1ns_i(eg1ns),
    .en_grp1s_i(eg1s), .single_sec_i(ss), .line_vld_i(lv), .line_idx_i(li), .line_lvl_i(ll),
    .cfg_we_i(cwe), .cfg_sel_i(csel), .cfg_num_i(cnum), .cfg_en_i(cen), .cfg_edge_i(ced),
    .cfg_prio_i(cpr), .cfg_tgt_i(ctg), .cfg_tgt_vld_i(ctv), .cfg_grp_i(cgr), .cfg_mod_i(cmd),
    .cfg_pend_i(cpd), .loc_vld_i(locv), .loc_num_i(locn), .loc_prio_i(locp),
    .scan_req_i(sreq), .busy_o(busy), .done_o(done), .best_vld_o(bv), .best_num_o(bn),
    .best_prio_o(bp), .ppi_vld_o(pv), .ppi_cpu_o(pc), .ppi_num_o(pn), .ppi_lvl_o(pl));

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference state, indexed by interrupt number
  bit m_pend[N], m_lvl[N], m_edg[N], m_en[N], m_grp[N], m_mod[N], m_tv[N];
  int m_prio[N], m_tgt[N];
  bit m_busy; int m_cnt;
  bit sb_v[NC]; int sb_n[NC], sb_p[NC];
  bit e_done, e_bv[NC]; int e_bn[NC], e_bp[NC];
  bit e_pv, e_pl; int e_pc, e_pn;

  function automatic bit m_elig(int n);
    bit act, m, gm;
    act = m_pend[n] | (!m_edg[n] & m_lvl[n]);
    m   = m_mod[n] & !ss;
    gm  = (eg1ns & m_grp[n]) | (eg1s & !m_grp[n] & m) | (eg0 & !m_grp[n] & !m);
    return act & m_en[n] & gm;
  endfunction

  task automatic snap_shared();
    for (int c = 0; c < NC; c++) begin
      sb_v[c] = 0; sb_n[c] = 0; sb_p[c] = 255;
      for (int n = 32; n < N; n++)
        if (m_elig(n) && m_tv[n] && m_tgt[n] == c && (!sb_v[c] || m_prio[n] < sb_p[c])) begin
          sb_v[c] = 1; sb_n[c] = n; sb_p[c] = m_prio[n];
        end
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      for (int n = 0; n < N; n++) begin
        m_pend[n] = 0; m_lvl[n] = 0; m_edg[n] = 0; m_en[n] = 0; m_mod[n] = 0;
        m_tv[n] = 0; m_prio[n] = 0; m_tgt[n] = 0; m_grp[n] = rst_nonsec;
      end
      m_busy = 0; m_cnt = 0; e_done = 0; e_pv = 0;
      for (int c = 0; c < NC; c++) begin e_bv[c] = 0; e_bn[c] = 0; e_bp[c] = 0; end
      return;
    end
    e_pv = lv && li >= NSH;
    e_pc = (int'(li) - NSH) / 32; e_pn = (int'(li) - NSH) % 32; e_pl = ll;
    e_done = 0;
    if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; e_done = 1;
        for (int c = 0; c < NC; c++) begin
          int lp;
          lp = int'(locp[c*8 +: 8]);
          if (locv[c] && (!sb_v[c] || lp <= sb_p[c])) begin
            e_bv[c] = 1; e_bn[c] = int'(locn[c*5 +: 5]); e_bp[c] = lp;
          end else begin
            e_bv[c] = sb_v[c]; e_bn[c] = sb_n[c]; e_bp[c] = sb_v[c] ? sb_p[c] : 255;
          end
        end
      end
    end else if (sreq) begin
      m_busy = 1; m_cnt = NSH / 32; snap_shared();
    end
    if (cwe && cnum >= 32 && int'(cnum) < N) begin
      case (csel)
        0: begin m_en[cnum] = cen; m_edg[cnum] = ced; m_prio[cnum] = cpr;
                 m_tgt[cnum] = ctg; m_tv[cnum] = ctv; end
        1: begin m_grp[cnum] = cgr; m_mod[cnum] = cmd; end
        2: m_pend[cnum] = cpd;
        default: ;
      endcase
    end
    if (lv && li < NSH) begin
      int n;
      n = int'(li) + 32;
      if (ll && !m_lvl[n] && m_edg[n]) m_pend[n] = 1;
      m_lvl[n] = ll;
    end
  endtask

  task automatic compare();
    n_cmp++;
    if (busy !== m_busy || done !== e_done) begin
      n_bad++;
      $display("FAIL R5 busy/done got %b/%b exp %b/%b", busy, done, m_busy, e_done);
    end
    for (int c = 0; c < NC; c++)
      if (bv[c] !== e_bv[c] || (e_bv[c] && (int'(bn[c*IW +: IW]) != e_bn[c] ||
          int'(bp[c*8 +: 8]) != e_bp[c]))) begin
        n_bad++;
        $display("FAIL R3 cpu%0d best got v%b n%0d p%0d exp v%b n%0d p%0d", c, bv[c],
                 bn[c*IW +: IW], bp[c*8 +: 8], e_bv[c], e_bn[c], e_bp[c]);
      end
    if (pv !== e_pv || (e_pv && (int'(pc) != e_pc || int'(pn) != e_pn || pl !== e_pl))) begin
      n_bad++;
      $display("FAIL R8 ppi got v%b c%0d n%0d l%b exp v%b c%0d n%0d l%b",
               pv, pc, pn, pl, e_pv, e_pc, e_pn, e_pl);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    compare();
  endtask

  task automatic chk_best(int c, bit v, int n, string req);
    n_cmp++;
    if (bv[c] !== v || (v && int'(bn[c*IW +: IW]) != n)) begin
      n_bad++;
      $display("FAIL %s cpu%0d got v%b n%0d exp v%b n%0d", req, c, bv[c], bn[c*IW +: IW], v, n);
    end
  endtask

  task automatic do_reset(bit ns);
    rst = 1; rst_nonsec = ns; tick(); tick(); rst = 0;
  endtask
  task automatic attr(int n, bit en, bit ed, int pr, int tg, bit tv);
    cwe = 1; csel = 0; cnum = IW'(n); cen = en; ced = ed; cpr = 8'(pr); ctg = CW'(tg); ctv = tv;
    tick(); cwe = 0;
  endtask
  task automatic sec(int n, bit g, bit m);
    cwe = 1; csel = 1; cnum = IW'(n); cgr = g; cmd = m; tick(); cwe = 0;
  endtask
  task automatic pnd(int n, bit p);
    cwe = 1; csel = 2; cnum = IW'(n); cpd = p; tick(); cwe = 0;
  endtask
  task automatic line(int idx, bit l);
    lv = 1; li = LIW'(idx); ll = l; tick(); lv = 0;
  endtask
  task automatic scan();
    sreq = 1; tick(); sreq = 0;
    for (int k = 0; k < NSH / 32; k++) tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs, group bits follow rst_nonsec_i
    do_reset(1);
    tick();
    chk_best(0, 0, 0, "R1");
    eg1ns = 1;
    attr(40, 1, 0, 10, 0, 1); pnd(40, 1);
    scan(); chk_best(0, 1, 40, "R1");
    do_reset(0);
    attr(40, 1, 0, 10, 0, 1); pnd(40, 1);
    scan(); chk_best(0, 0, 0, "R1");

    // R3: per-cpu routing, priority, equal-priority tie to lower number
    eg0 = 1; eg1s = 1;
    attr(33, 1, 0, 5, 1, 1); pnd(33, 1);
    attr(70, 1, 0, 5, 1, 1); pnd(70, 1);
    attr(50, 1, 0, 3, 0, 1); pnd(50, 1);
    attr(90, 1, 0, 3, 0, 1); pnd(90, 1);
    scan(); chk_best(0, 1, 50, "R3"); chk_best(1, 1, 33, "R3");

    // R4: unimplemented targets skipped, pending kept across retarget
    attr(35, 1, 1, 1, 3, 1);
    attr(36, 1, 1, 0, 0, 0);
    line(4, 1);
    pnd(35, 1);
    scan(); chk_best(0, 1, 50, "R4"); chk_best(1, 1, 33, "R4");
    attr(36, 1, 1, 0, 0, 1);
    scan(); chk_best(0, 1, 36, "R4");
    attr(36, 0, 1, 0, 0, 1); attr(35, 0, 1, 1, 3, 1);

    // R2/R7: level-type follows line; edge-type needs rising edge
    attr(80, 1, 0, 0, 1, 1);
    line(48, 1);
    scan(); chk_best(1, 1, 80, "R7");
    line(48, 0);
    scan(); chk_best(1, 1, 33, "R2");
    attr(33, 0, 0, 5, 1, 1);
    scan(); chk_best(1, 1, 70, "R2");

    // R10: secure group-1 via modifier, then single-security mode
    eg0 = 0; eg1ns = 0; eg1s = 1;
    sec(60, 0, 1); attr(60, 1, 0, 7, 0, 1); pnd(60, 1);
    scan(); chk_best(0, 1, 60, "R10");
    ss = 1;
    scan(); chk_best(0, 0, 0, "R10");
    ss = 0; eg0 = 1; eg1ns = 1;

    // R6: private candidate merge
    locv = 2'b01; locn[4:0] = 5'd20; locp[7:0] = 8'd3;
    scan(); chk_best(0, 1, 20, "R6");
    locp[7:0] = 8'd4;
    scan(); chk_best(0, 1, 50, "R6");
    locv = 2'b11; locn[9:5] = 5'd7; locp[15:8] = 8'd200;
    attr(70, 0, 0, 5, 1, 1);
    scan(); chk_best(1, 1, 7, "R6");
    locv = 0;

    // R5: request while busy ignored
    sreq = 1; tick(); tick(); sreq = 0;
    for (int k = 0; k < 3; k++) tick();

    // R3: priority 0xFF can still win
    attr(50, 0, 0, 3, 0, 1); attr(90, 0, 0, 3, 0, 1); attr(60, 0, 0, 7, 0, 1);
    attr(40, 1, 0, 255, 0, 1);
    scan(); chk_best(0, 1, 40, "R3");

    // R9: out-of-range and unused-select writes change nothing
    cwe = 1; csel = 3; cnum = 7'd40; cen = 0; tick(); cwe = 0;
    cwe = 1; csel = 0; cnum = 7'd8;  cen = 1; cpr = 0; ctg = 0; ctv = 1; tick(); cwe = 0;
    cwe = 1; csel = 0; cnum = 7'd100; tick(); cwe = 0;
    scan(); chk_best(0, 1, 40, "R9");

    // R8: private line decode
    line(64, 1); line(127, 0); line(95, 1); line(63, 1);
    tick(); tick();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule